// File: doc/BRIEF.md
# Dual Capture/Compare Up-Counter Timer

This block is a free-running or self-clearing up-counter with two general registers beside it. Each register can act in either of two roles. In its compare role it is checked against the count every time the count steps up, and a match gives a one-cycle interrupt pulse. In its capture role it takes a snapshot of the count when a chosen edge arrives on an external trigger pin. Register 1 captures on trigger 0, and register 0 captures on trigger 1. A control register holds these settings: run/stop, the counting mode, the role of each register and the edge selection for each trigger pin.

There are four counting modes. In free-running mode the counter wraps from the all-ones value to zero and sets a sticky overflow flag. In match-clear mode, a match on register 0 restarts the count from zero. In trigger-clear mode, a valid edge on trigger 0 restarts the count. The fourth code behaves as free-running. A compare only matches when the counter steps into a value. As a result, a compare value of zero fires only on the wrap. A compare value moved below the current count is also not seen until the counter has wrapped. Software writes and reads the registers through a simple address-decoded port. The trigger pins are asynchronous and pass through a synchronizer.

Top module: `cctmr_top`

## Requirements
- R1: After reset the count, both general registers, the control register, both interrupts and the overflow flag are all zero.
- R2: The control register fields are: bit 0 run, bits 2:1 mode (0 free-run, 1 match-clear, 2 trigger-clear, 3 free-run), bit 3 register-0 capture role, bit 4 register-1 capture role, bits 6:5 trigger-0 edge, bits 8:7 trigger-1 edge. While run is 1 the count rises by one per clock. While run is 0 the count holds.
- R3: A register in its compare role pulses its interrupt for exactly one cycle, in the cycle when the count has just stepped up to that register's value. A compare value of zero therefore fires only when the count wraps from all ones to zero.
- R4: In match-clear mode, with register 0 in its compare role, the clock after a register-0 match loads zero. The count period is therefore the register-0 value plus one.
- R5: If register 0 is lowered below the current count in match-clear mode, the count keeps rising to all ones, wraps, and only then can match.
- R6: The overflow flag sets when the count wraps from all ones to zero. It stays set until the next write to the control register.
- R7: The edge code is 0 falling, 1 rising, 2 none, 3 both. A trigger level change is sampled at a clock edge k. Register 1 in its capture role then loads the count value present just before clock edge k+2.
- R8: Register 0 in its capture role loads the count on a valid edge of trigger 1, selected by bits 8:7, with the same latency as R7.
- R9: Edge code 2 never captures. While run is 0, trigger edges neither capture nor clear.
- R10: A register written while the counter runs is used from the following compare onward.
- R11: When a capture and a bus write hit the same register in the same clock, the captured value is stored. A read in that cycle returns the previous value, and the next cycle reads the captured value.
- R12: In trigger-clear mode, a valid trigger-0 edge loads zero into the count at the same clock where register 1, if it is in its capture role, takes the count from before the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address: 0 register 0, 1 register 1, 2 control |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address, same map; 3 reads zero |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| trig0 | input | 1 | Asynchronous trigger 0 |
| trig1 | input | 1 | Asynchronous trigger 1 |
| irq0 | output | 1 | Register-0 match pulse |
| irq1 | output | 1 | Register-1 match pulse |
| count | output | 16 | Current count |
| ovf | output | 1 | Sticky wrap flag |

## Verification
The hardest cases to reach are the ones that depend on the counter wrapping: the missed match after register 0 is lowered, the zero-value compare, and the overflow flag. Reaching them takes about 65,000 counting cycles. One directed run lowers register 0 at a known count and then lets the counter go all the way round, with register 1 left at zero. The cycle-exact capture/write collision is reached by counting clock edges from the trigger change, so that the bus write lands on the capture clock. A long random phase runs alongside a cycle-level reference model and mixes mode changes, writes and trigger toggles.

// File: rtl/cctmr_pkg.sv
package cctmr_pkg;

    localparam int CTRL_W   = 9;
    localparam int NCH      = 2;

    localparam logic [1:0] ADDR_CC0  = 2'd0;
    localparam logic [1:0] ADDR_CC1  = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;

    typedef enum logic [1:0] {
        MODE_FREE      = 2'd0,
        MODE_CLR_MATCH = 2'd1,
        MODE_CLR_TRIG  = 2'd2,
        MODE_FREE_ALT  = 2'd3
    } tmr_mode_e;

    typedef enum logic [1:0] {
        EDGE_FALL = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_NONE = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_sel_e;

    typedef struct packed {
        edge_sel_e esel1;
        edge_sel_e esel0;
        logic      cap1;
        logic      cap0;
        tmr_mode_e mode;
        logic      run;
    } ctrl_t;

endpackage

// File: rtl/cctmr_edge_det.sv
module cctmr_edge_det
    import cctmr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin,
    input  edge_sel_e sel,
    output logic      valid
);

    typedef struct packed {
        logic s1;
        logic s2;
        logic dly;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.s1  = pin;
        sync_d.s2  = sync_q.s1;
        sync_d.dly = sync_q.s2;
        unique case (sel)
            EDGE_FALL: valid = ~sync_q.s2 &  sync_q.dly;
            EDGE_RISE: valid =  sync_q.s2 & ~sync_q.dly;
            EDGE_BOTH: valid =  sync_q.s2 ^  sync_q.dly;
            default:   valid = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

endmodule

// File: rtl/cctmr_ccreg.sv
module cctmr_ccreg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_mode,
    input  logic         run,
    input  logic         step,
    input  logic [W-1:0] step_val,
    input  logic [W-1:0] count,
    input  logic         cap_evt,
    input  logic         wr_hit,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] value,
    output logic         match
);

    typedef struct packed {
        logic [W-1:0] val;
        logic         hit;
    } cc_state_t;

    cc_state_t cc_d, cc_q;

    always_comb begin
        cc_d = cc_q;
        // capture outranks a same-cycle bus write
        if (run && cap_mode && cap_evt) begin
            cc_d.val = count;
        end else if (wr_hit) begin
            cc_d.val = wr_data;
        end
        // compare only on a counting step into the stored value
        cc_d.hit = step && !cap_mode && (step_val == cc_q.val);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cc_q <= '0;
        else        cc_q <= cc_d;
    end

    assign value = cc_q.val;
    assign match = cc_q.hit;

endmodule

// File: rtl/cctmr_top.sv
module cctmr_top
    import cctmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    input  logic             trig0,
    input  logic             trig1,
    output logic             irq0,
    output logic             irq1,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);

    localparam int PAD_W = CNT_W - CTRL_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
        ctrl_t            ctrl;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [NCH-1:0]   trig_in;
    logic [NCH-1:0]   edge_hit;
    logic [NCH-1:0]   match;
    logic [NCH-1:0]   cap_mode;
    edge_sel_e        esel [NCH];
    logic [CNT_W-1:0] cc_val [NCH];

    logic             clr_trig;
    logic             clr_match;
    logic             step;
    logic             wrap;
    logic             ctrl_wr;
    logic [CNT_W-1:0] cnt_inc;

    // signals observed by the bound checker
    logic             run_w;
    logic [1:0]       mode_w;
    logic             cap0_w;
    logic [CNT_W-1:0] reg0_w;

    assign trig_in = {trig1, trig0};

    always_comb begin
        cap_mode = {st_q.ctrl.cap1, st_q.ctrl.cap0};
        esel[0]  = st_q.ctrl.esel0;
        esel[1]  = st_q.ctrl.esel1;
    end

    for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
        cctmr_edge_det u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (trig_in[gi]),
            .sel   (esel[gi]),
            .valid (edge_hit[gi])
        );

        // register gi captures on the other channel's trigger
        cctmr_ccreg #(.W(CNT_W)) u_cc (
            .clk      (clk),
            .rst_n    (rst_n),
            .cap_mode (cap_mode[gi]),
            .run      (st_q.ctrl.run),
            .step     (step),
            .step_val (cnt_inc),
            .count    (st_q.cnt),
            .cap_evt  (edge_hit[NCH-1-gi]),
            .wr_hit   (bus_wr && (wr_addr == 2'(gi))),
            .wr_data  (wr_data),
            .value    (cc_val[gi]),
            .match    (match[gi])
        );
    end

    always_comb begin
        st_d      = st_q;
        ctrl_wr   = bus_wr && (wr_addr == ADDR_CTRL);
        cnt_inc   = st_q.cnt + 1'b1;
        clr_trig  = st_q.ctrl.run && (st_q.ctrl.mode == MODE_CLR_TRIG) && edge_hit[0];
        clr_match = st_q.ctrl.run && (st_q.ctrl.mode == MODE_CLR_MATCH)
                    && !st_q.ctrl.cap0 && match[0];
        step      = st_q.ctrl.run && !clr_trig && !clr_match;
        wrap      = step && (st_q.cnt == '1);

        if (ctrl_wr) begin
            st_d.ctrl = ctrl_t'(wr_data[CTRL_W-1:0]);
        end

        if (clr_trig || clr_match) begin
            st_d.cnt = '0;
        end else if (step) begin
            st_d.cnt = cnt_inc;
        end

        if (ctrl_wr) st_d.ovf = 1'b0;
        if (wrap)    st_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (rd_addr)
            ADDR_CC0:  rd_data = cc_val[0];
            ADDR_CC1:  rd_data = cc_val[1];
            ADDR_CTRL: rd_data = {{PAD_W{1'b0}}, st_q.ctrl};
            default:   rd_data = '0;
        endcase
    end

    assign count  = st_q.cnt;
    assign ovf    = st_q.ovf;
    assign irq0   = match[0];
    assign irq1   = match[1];
    assign run_w  = st_q.ctrl.run;
    assign mode_w = st_q.ctrl.mode;
    assign cap0_w = st_q.ctrl.cap0;
    assign reg0_w = cc_val[0];

endmodule

// File: rtl/cctmr_chk.sv
module cctmr_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic [1:0]       mode,
    input logic             cap0,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] reg0,
    input logic             irq0,
    input logic             ovf
);

    assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> count == $past(count));

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && mode == 2'd0) |=> count == $past(count) + 16'd1);

    assert_irq_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq0 && $stable(reg0)) |=> !irq0);

    assert_irq_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq0 |-> count == $past(reg0));

    assert_clear_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && mode == 2'd1 && !cap0 && irq0) |=> count == '0);

    assert_ovf_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(count) == '1);

endmodule

bind cctmr_top cctmr_chk #(.CNT_W(CNT_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_w),
    .mode  (mode_w),
    .cap0  (cap0_w),
    .count (count),
    .reg0  (reg0_w),
    .irq0  (irq0),
    .ovf   (ovf)
);

// File: tb/tb_cctmr_top.sv
module tb_cctmr_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        trig0 = 1'b0;
    logic        trig1 = 1'b0;
    logic        irq0, irq1, ovf;
    logic [15:0] count;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cctmr_top dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .trig0(trig0), .trig1(trig1), .irq0(irq0), .irq1(irq1),
        .count(count), .ovf(ovf)
    );

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    logic [15:0] m_cnt, m_r0, m_r1;
    logic [8:0]  m_ctrl;
    logic        m_ovf, m_irq0, m_irq1;
    logic [1:0]  m_s1, m_s2, m_dl;

    function automatic logic edge_ok(logic cur, logic prev, logic [1:0] code);
        case (code)
            2'd0: return !cur && prev;
            2'd1: return cur && !prev;
            2'd3: return cur != prev;
            default: return 1'b0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_r0 = 0; m_r1 = 0; m_ctrl = 0;
            m_ovf = 0; m_irq0 = 0; m_irq1 = 0;
            m_s1 = 0; m_s2 = 0; m_dl = 0;
        end else begin
            logic run, cap0, cap1, e0, e1, clr, stp, n_i0, n_i1, n_ovf;
            logic [1:0] mode;
            logic [15:0] nxt, n_r0, n_r1, n_cnt;
            logic [8:0] n_ctrl;
            run  = m_ctrl[0]; mode = m_ctrl[2:1];
            cap0 = m_ctrl[3]; cap1 = m_ctrl[4];
            e0 = edge_ok(m_s2[0], m_dl[0], m_ctrl[6:5]);
            e1 = edge_ok(m_s2[1], m_dl[1], m_ctrl[8:7]);
            clr = run && ((mode == 2 && e0) || (mode == 1 && !cap0 && m_irq0));
            stp = run && !clr;
            nxt = m_cnt + 16'd1;
            n_i0 = stp && !cap0 && nxt == m_r0;
            n_i1 = stp && !cap1 && nxt == m_r1;
            n_r0 = (run && cap0 && e1) ? m_cnt : (bus_wr && wr_addr == 0) ? wr_data : m_r0;
            n_r1 = (run && cap1 && e0) ? m_cnt : (bus_wr && wr_addr == 1) ? wr_data : m_r1;
            n_cnt = !run ? m_cnt : clr ? 16'd0 : nxt;
            n_ovf = (stp && m_cnt == 16'hFFFF) ? 1'b1 : (bus_wr && wr_addr == 2) ? 1'b0 : m_ovf;
            n_ctrl = (bus_wr && wr_addr == 2) ? wr_data[8:0] : m_ctrl;
            m_cnt = n_cnt; m_r0 = n_r0; m_r1 = n_r1; m_ctrl = n_ctrl;
            m_ovf = n_ovf; m_irq0 = n_i0; m_irq1 = n_i1;
            m_dl = m_s2; m_s2 = m_s1; m_s1 = {trig1, trig0};
        end
    end

    always @(negedge clk) begin
        #2;
        if (rst_n && !done) begin
            logic [15:0] exp_rd;
            case (rd_addr)
                2'd0: exp_rd = m_r0;
                2'd1: exp_rd = m_r1;
                2'd2: exp_rd = {7'd0, m_ctrl};
                default: exp_rd = 0;
            endcase
            check("R2 count vs model", count, m_cnt);
            check("R3 irq0 vs model", {15'd0, irq0}, {15'd0, m_irq0});
            check("R3 irq1 vs model", {15'd0, irq1}, {15'd0, m_irq1});
            check("R6 ovf vs model", {15'd0, ovf}, {15'd0, m_ovf});
            check("R7 rd_data vs model", rd_data, exp_rd);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; bus_wr = 0; trig0 = 0; trig1 = 0; rd_addr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        bus_wr = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd_chk(string tag, logic [1:0] a, logic [15:0] exp);
        rd_addr = a;
        #1;
        check(tag, rd_data, exp);
    endtask

    // drive trigger level at a negedge, return count just before capture edge
    task automatic trig_seq(int which, logic lvl, output logic [15:0] exp);
        @(negedge clk);
        if (which == 0) trig0 = lvl; else trig1 = lvl;
        repeat (2) @(negedge clk);
        exp = count;
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] e, old, cur;
        int pulses, maxc, n;
        bit seen;
        void'($urandom(32'd20240611));

        // R1 reset values
        do_reset();
        check("R1 count", count, 0);
        check("R1 irq", {14'd0, irq1, irq0}, 0);
        check("R1 ovf", {15'd0, ovf}, 0);
        rd_chk("R1 reg0", 0, 0);
        rd_chk("R1 reg1", 1, 0);
        rd_chk("R1 ctrl", 2, 0);

        // R4 match-clear period
        wr(0, 16'd5);
        wr(2, 16'h0003);
        pulses = 0; maxc = 0;
        repeat (60) begin
            @(negedge clk);
            if (irq0) pulses++;
            if (int'(count) > maxc) maxc = int'(count);
        end
        check("R4 pulses in 60 cycles", 16'(pulses), 16'd10);
        check("R4 max count", 16'(maxc), 16'd5);

        // R10 and R3: rewrite compare while running
        do_reset();
        wr(1, 16'd30);
        wr(2, 16'h0001);
        n = 0;
        while (!irq1 && n < 100) begin @(negedge clk); n++; end
        check("R3 irq1 at count", count, 16'd30);
        @(negedge clk);
        check("R3 irq1 single cycle", {15'd0, irq1}, 0);
        cur = count;
        bus_wr = 1; wr_addr = 1; wr_data = cur + 16'd10;
        @(negedge clk); bus_wr = 0;
        n = 0;
        while (!irq1 && n < 100) begin @(negedge clk); n++; end
        check("R10 new compare used", count, cur + 16'd10);

        // R7 capture into reg1 from trig0, edge codes
        do_reset();
        wr(2, 16'd49);                     // run, cap1, esel0 rising
        repeat (10) @(negedge clk);
        trig_seq(0, 1'b1, e);
        rd_chk("R7 rising capture", 1, e);
        old = e;
        trig_seq(0, 1'b0, e);
        rd_chk("R7 falling ignored by rising code", 1, old);
        wr(2, 16'd17);                     // falling
        trig_seq(0, 1'b1, e);
        rd_chk("R7 rising ignored by falling code", 1, old);
        trig_seq(0, 1'b0, e);
        rd_chk("R7 falling capture", 1, e);
        wr(2, 16'd113);                    // both
        trig_seq(0, 1'b1, e);
        rd_chk("R7 both rising", 1, e);
        trig_seq(0, 1'b0, e);
        rd_chk("R7 both falling", 1, e);
        old = e;

        // R9 reserved code and stopped timer
        wr(2, 16'd81);                     // code 2
        trig_seq(0, 1'b1, e);
        trig_seq(0, 1'b0, e);
        rd_chk("R9 code 2 no capture", 1, old);
        wr(2, 16'd112);                    // both, run=0
        cur = count;
        trig_seq(0, 1'b1, e);
        rd_chk("R9 stopped no capture", 1, old);
        check("R2 count held while stopped", count, cur);

        // R8 reg0 capture from trig1
        wr(2, 16'd137);                    // run, cap0, esel1 rising
        repeat (5) @(negedge clk);
        trig_seq(1, 1'b1, e);
        rd_chk("R8 reg0 capture", 0, e);

        // R11 capture and write collide
        wr(2, 16'd49);
        trig0 = 1'b0;
        repeat (6) @(negedge clk);
        rd_addr = 1; #1; old = rd_data;
        @(negedge clk); trig0 = 1'b1;
        repeat (2) @(negedge clk);
        e = count;
        bus_wr = 1; wr_addr = 1; wr_data = 16'hABCD;
        #1;
        check("R11 read during capture cycle", rd_data, old);
        @(negedge clk); bus_wr = 0;
        #1;
        check("R11 capture wins over write", rd_data, e);

        // R12 trigger-clear mode
        do_reset();
        wr(2, 16'd53);                     // run, mode 2, cap1, esel0 rising
        repeat (20) @(negedge clk);
        trig_seq(0, 1'b1, e);
        rd_chk("R12 pre-clear capture", 1, e);
        check("R12 count cleared", count, 16'd0);
        @(negedge clk);
        check("R12 count restarts", count, 16'd1);

        // R5, R6, zero compare in R3
        do_reset();
        wr(0, 16'd100);
        wr(2, 16'h0003);
        n = 0;
        while (count != 16'd50 && n < 200) begin @(negedge clk); n++; end
        bus_wr = 1; wr_addr = 0; wr_data = 16'd20;
        @(negedge clk); bus_wr = 0;
        seen = 0;
        repeat (200) begin @(negedge clk); if (irq1) seen = 1; end
        check("R5 count passes lowered compare", count, 16'd251);
        n = 0;
        while (!ovf && n < 70000) begin
            @(negedge clk); n++;
            if (irq1 && !ovf) seen = 1;
        end
        check("R3 zero compare silent before wrap", {15'd0, seen}, 0);
        check("R6 ovf at wrap", {15'd0, ovf}, 1);
        check("R3 zero compare fires on wrap", {15'd0, irq1}, 1);
        check("R6 count after wrap", count, 0);
        n = 0;
        while (!irq0 && n < 100) begin @(negedge clk); n++; end
        check("R5 match after wrap", count, 16'd20);
        check("R6 ovf sticky", {15'd0, ovf}, 1);
        wr(2, 16'h0003);
        check("R6 ovf cleared by ctrl write", {15'd0, ovf}, 0);

        // random phase against the model
        do_reset();
        repeat (20000) begin
            int r;
            @(negedge clk);
            bus_wr = 0;
            rd_addr = 2'($urandom_range(0, 3));
            r = $urandom_range(0, 99);
            if (r < 8) begin
                bus_wr = 1;
                wr_addr = 2'($urandom_range(0, 2));
                if (wr_addr == 2)
                    wr_data = {7'd0, 9'($urandom)} | (($urandom_range(0, 9) < 8) ? 16'd1 : 16'd0);
                else
                    wr_data = ($urandom_range(0, 3) != 0) ? count + 16'($urandom_range(1, 64))
                                                          : 16'($urandom);
            end else if (r < 14) begin
                trig0 = ~trig0;
            end else if (r < 20) begin
                trig1 = ~trig1;
            end
        end
        @(negedge clk); bus_wr = 0;
        repeat (4) @(negedge clk);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule